// File: doc/BRIEF.md
# Debug Entry and Fault Status Capture

This block sits beside a processor pipeline and decides when the core must enter debug. It holds the debug control and status register and compares the program counter against two instruction breakpoint registers. It also sees pulses for a data breakpoint hit and for an executed breakpoint instruction. When global debug is enabled it records which source caused entry in a three-bit method-of-entry field and raises a one-cycle trap request.

The same block captures a fault status code and a fault address for prefetch aborts, data aborts in multiple-register transfers and breakpoint instructions. Capture happens only while global debug is enabled. Software writes the control and status register through a plain write strobe, and reads it, the fault status and the fault address from the output ports. Processor mode switching is left to the core.

Top module: `dbg_entry_unit`

## Requirements
- R1: After synchronous active-low reset, `trap_req` is 0 and `csr_rdata`, `fsr_q` and `far_q` are all zero.
- R2: An instruction breakpoint register matches when its bit 0 is 1 and its bits [31:2] equal `pc[31:2]` while `pc_valid` is 1. Bits [1:0] of `pc` and bit 1 of the register are ignored. Either of the two registers may match.
- R3: On a debug entry event the method-of-entry field `csr_rdata[4:2]` is written with 1 for an instruction breakpoint, 2 for a data breakpoint and 3 for a breakpoint instruction, and every other bit of the register keeps its value.
- R4: While global debug enable `csr_rdata[31]` is 0, no event changes the register, raises `trap_req`, or changes `fsr_q` or `far_q`.
- R5: When several entry events arrive in one cycle, the recorded code follows the priority instruction breakpoint, then breakpoint instruction, then data breakpoint.
- R6: `trap_req` is high for exactly the cycle after each cycle that holds an entry event with debug enabled. Events in consecutive cycles give consecutive high cycles.
- R7: A breakpoint instruction or a prefetch abort, with debug enabled, loads `fsr_q` with 0x400 and `far_q` with `pc`.
- R8: A data abort, with debug enabled, loads `fsr_q` with 0x001 and `far_q` with `dabort_addr`.
- R9: If a data abort occurs in the same cycle as a breakpoint instruction or a prefetch abort, the instruction-side capture (0x400, `pc`) wins.
- R10: A software write in the same cycle as an entry event stores the written value unchanged, with no method-of-entry merge. The trap request still follows the enable bit held before that write.
- R11: With `pc_valid` low, or with bit 0 of a breakpoint register clear, that register never causes an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_wr_en | input | 1 | Software write strobe for the control/status register |
| csr_wr_data | input | 32 | Value written to the control/status register |
| pc_valid | input | 1 | `pc` holds an instruction about to execute |
| pc | input | 32 | Program counter |
| ibp_regs | input | 2x32 | Instruction breakpoint registers: word address in [31:2], enable in [0] |
| dbp_hit | input | 1 | Data breakpoint hit pulse |
| bkpt_insn | input | 1 | Breakpoint instruction executed |
| pabort | input | 1 | Prefetch abort pulse |
| dabort | input | 1 | Data abort in a multiple-register transfer |
| dabort_addr | input | 32 | Transfer address of the data abort |
| trap_req | output | 1 | One-cycle debug trap request |
| csr_rdata | output | 32 | Control/status register: [31] enable, [4:2] method of entry |
| fsr_q | output | 11 | Fault status |
| far_q | output | 32 | Fault address |

## Verification
The hardest case to reach is a cycle where several sources coincide. Examples are an instruction breakpoint, a breakpoint instruction and a data breakpoint together, or a data abort beside a prefetch abort, or a software write landing in the same cycle as an event. The bench drives these collisions as directed steps. It then runs a long random phase in which every pulse input and the write strobe toggle independently, and a behavioural model predicts every output on every cycle. Breakpoint addresses in the random phase come from a small pool that shares high bits with the PC, so matches, near misses in bits [1:0] and disabled registers all occur often.

// File: rtl/dbg_entry_pkg.sv
// Shared constants and types for the debug entry unit.
// Assumes a 32-bit control/status register with enable at bit 31.
package dbg_entry_pkg;
    localparam int CSR_W   = 32;
    localparam int EN_BIT  = 31;
    localparam int MOE_LSB = 2;
    localparam int MOE_MSB = 4;
    localparam int FSR_W   = 11;

    typedef enum logic [2:0] {
        MOE_NONE = 3'd0,
        MOE_IBP  = 3'd1,
        MOE_DBP  = 3'd2,
        MOE_BKPT = 3'd3
    } moe_code_e;

    localparam logic [FSR_W-1:0] FSR_INSN_SIDE = 11'h400;
    localparam logic [FSR_W-1:0] FSR_XFER      = 11'h001;
endpackage

// File: rtl/ibp_compare.sv
// Instruction breakpoint comparators, one per breakpoint register.
// Assumes register bit 0 enables the entry and bits [AW-1:2] hold a word address.
module ibp_compare #(
    parameter int AW      = 32,
    parameter int NUM_IBP = 2
) (
    input  logic                         pc_valid,
    input  logic [AW-1:0]                pc,
    input  logic [NUM_IBP-1:0][AW-1:0]   ibp_regs,
    output logic                         hit
);
    localparam logic [AW-1:0] WORD_MASK = ~(AW'(3));

    logic [NUM_IBP-1:0] slot_hit;

    genvar i;
    generate
        for (i = 0; i < NUM_IBP; i++) begin : g_slot
            // One comparator: enabled slot whose word address equals the PC's.
            assign slot_hit[i] = ibp_regs[i][0] &&
                                 (((ibp_regs[i] ^ pc) & WORD_MASK) == '0);
        end
    endgenerate

    // Any enabled slot matching a valid PC is a hit.
    assign hit = pc_valid && (|slot_hit);
endmodule

// File: rtl/dbg_event_arb.sv
// Picks one entry source per cycle and its method-of-entry code.
// Assumes the event inputs are single-cycle pulses.
module dbg_event_arb
    import dbg_entry_pkg::*;
(
    input  logic      dbg_en,
    input  logic      ibp_hit,
    input  logic      bkpt_insn,
    input  logic      dbp_hit,
    output logic      take,
    output moe_code_e moe
);
    // Fixed priority: instruction breakpoint, breakpoint instruction, data breakpoint.
    always_comb begin
        moe = MOE_NONE;
        if (ibp_hit)        moe = MOE_IBP;
        else if (bkpt_insn) moe = MOE_BKPT;
        else if (dbp_hit)   moe = MOE_DBP;
        take = dbg_en && (moe != MOE_NONE);
    end
endmodule

// File: rtl/fault_capture.sv
// Fault status and fault address registers.
// Assumes the capture is allowed only while debug is enabled.
module fault_capture
    import dbg_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_en,
    input  logic             bkpt_insn,
    input  logic             pabort,
    input  logic             dabort,
    input  logic [AW-1:0]    pc,
    input  logic [AW-1:0]    dabort_addr,
    output logic [FSR_W-1:0] fsr_q,
    output logic [AW-1:0]    far_q
);
    // Capture status and address; instruction-side faults outrank a data abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr_q <= '0;
            far_q <= '0;
        end else if (dbg_en) begin
            if (bkpt_insn || pabort) begin
                fsr_q <= FSR_INSN_SIDE;
                far_q <= pc;
            end else if (dabort) begin
                fsr_q <= FSR_XFER;
                far_q <= dabort_addr;
            end
        end
    end
endmodule

// File: rtl/dbg_entry_unit.sv
// Debug entry unit: holds the control/status register, arbitrates entry
// events, raises a one-cycle trap request and captures fault status/address.
// Assumes events are pulses aligned to clk; mode switching is done elsewhere.
module dbg_entry_unit
    import dbg_entry_pkg::*;
#(
    parameter int AW      = 32,
    parameter int NUM_IBP = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        csr_wr_en,
    input  logic [CSR_W-1:0]            csr_wr_data,
    input  logic                        pc_valid,
    input  logic [AW-1:0]               pc,
    input  logic [NUM_IBP-1:0][AW-1:0]  ibp_regs,
    input  logic                        dbp_hit,
    input  logic                        bkpt_insn,
    input  logic                        pabort,
    input  logic                        dabort,
    input  logic [AW-1:0]               dabort_addr,
    output logic                        trap_req,
    output logic [CSR_W-1:0]            csr_rdata,
    output logic [FSR_W-1:0]            fsr_q,
    output logic [AW-1:0]               far_q
);
    logic      dbg_en;
    logic      ibp_hit;
    logic      take;
    moe_code_e moe;
    logic [CSR_W-1:0] csr_q;

    assign dbg_en = csr_q[EN_BIT];

    ibp_compare #(.AW(AW), .NUM_IBP(NUM_IBP)) u_ibp (
        .pc_valid (pc_valid),
        .pc       (pc),
        .ibp_regs (ibp_regs),
        .hit      (ibp_hit)
    );

    dbg_event_arb u_arb (
        .dbg_en    (dbg_en),
        .ibp_hit   (ibp_hit),
        .bkpt_insn (bkpt_insn),
        .dbp_hit   (dbp_hit),
        .take      (take),
        .moe       (moe)
    );

    fault_capture #(.AW(AW)) u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbg_en      (dbg_en),
        .bkpt_insn   (bkpt_insn),
        .pabort      (pabort),
        .dabort      (dabort),
        .pc          (pc),
        .dabort_addr (dabort_addr),
        .fsr_q       (fsr_q),
        .far_q       (far_q)
    );

    // Control/status register: software write wins, else merge the entry code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else if (csr_wr_en) begin
            csr_q <= csr_wr_data;
        end else if (take) begin
            csr_q[MOE_MSB:MOE_LSB] <= moe;
        end
    end

    // Trap request: one cycle after each accepted entry event.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_req <= 1'b0;
        else        trap_req <= take;
    end

    assign csr_rdata = csr_q;
endmodule

// File: rtl/dbg_entry_unit_chk.sv
// Property checker for the debug entry unit, bound to every instance.
// Assumes the signal names of the top module's ports.
module dbg_entry_unit_chk
    import dbg_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csr_wr_en,
    input logic             bkpt_insn,
    input logic             pabort,
    input logic             dabort,
    input logic             trap_req,
    input logic [CSR_W-1:0] csr_rdata,
    input logic [FSR_W-1:0] fsr_q,
    input logic [AW-1:0]    far_q
);
    // R4: a trap needs the enable bit set in the previous cycle
    p_trap_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(csr_rdata[EN_BIT]));

    // R4: disabled and unwritten register does not move
    p_csr_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_rdata[EN_BIT] && !csr_wr_en) |=> $stable(csr_rdata));

    // R4: fault registers frozen while disabled
    p_fault_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rdata[EN_BIT] |=> ($stable(fsr_q) && $stable(far_q)));

    // R3: a trap without a colliding write shows a legal entry code
    p_trap_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !$past(csr_wr_en)) |->
            (csr_rdata[MOE_MSB:MOE_LSB] inside {3'd1, 3'd2, 3'd3}));

    // R7: fault status only ever holds a defined code
    p_fsr_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsr_q == '0) || (fsr_q == FSR_INSN_SIDE) || (fsr_q == FSR_XFER));

    // R8: no fault event, no change in fault registers
    p_fault_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bkpt_insn || pabort || dabort) |=> ($stable(fsr_q) && $stable(far_q)));
endmodule

bind dbg_entry_unit dbg_entry_unit_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr_en (csr_wr_en),
    .bkpt_insn (bkpt_insn),
    .pabort    (pabort),
    .dabort    (dabort),
    .trap_req  (trap_req),
    .csr_rdata (csr_rdata),
    .fsr_q     (fsr_q),
    .far_q     (far_q)
);

// File: tb/dbg_entry_unit_tb_top.sv
// Bench: directed collisions plus a random phase, against a behavioural model.
module dbg_entry_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr_en = 1'b0;
    logic [31:0] csr_wr_data = '0;
    logic        pc_valid = 1'b0;
    logic [31:0] pc = '0;
    logic [1:0][31:0] ibp_regs = '0;
    logic        dbp_hit = 1'b0;
    logic        bkpt_insn = 1'b0;
    logic        pabort = 1'b0;
    logic        dabort = 1'b0;
    logic [31:0] dabort_addr = '0;
    logic        trap_req;
    logic [31:0] csr_rdata;
    logic [10:0] fsr_q;
    logic [31:0] far_q;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state
    bit          m_trap = 0;
    logic [31:0] m_csr = '0;
    logic [31:0] m_fsr = '0;
    logic [31:0] m_far = '0;

    always #5 clk = ~clk;

    dbg_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
        .pc_valid(pc_valid), .pc(pc), .ibp_regs(ibp_regs), .dbp_hit(dbp_hit),
        .bkpt_insn(bkpt_insn), .pabort(pabort), .dabort(dabort),
        .dabort_addr(dabort_addr), .trap_req(trap_req), .csr_rdata(csr_rdata),
        .fsr_q(fsr_q), .far_q(far_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit slot_match(input logic [31:0] r, input logic [31:0] p);
        return r[0] == 1'b1 && (r >> 2) == (p >> 2);
    endfunction

    // one clock: model update after the edge, compare at the falling edge
    task automatic step();
        bit ih, en;
        int code;
        @(posedge clk);
        en = m_csr[31];
        ih = pc_valid && (slot_match(ibp_regs[0], pc) || slot_match(ibp_regs[1], pc));
        code = ih ? 1 : (bkpt_insn ? 3 : (dbp_hit ? 2 : 0));
        if (!rst_n) begin
            m_trap = 0; m_csr = 0; m_fsr = 0; m_far = 0;
        end else begin
            m_trap = en && code != 0;
            if (en && (bkpt_insn || pabort)) begin m_fsr = 32'h400; m_far = pc; end
            else if (en && dabort) begin m_fsr = 32'h1; m_far = dabort_addr; end
            if (csr_wr_en) m_csr = csr_wr_data;
            else if (en && code != 0) m_csr = (m_csr & ~32'h1c) | (32'(code) << 2);
        end
        @(negedge clk);
        chk("R6 trap_req", {31'b0, trap_req}, {31'b0, m_trap});
        chk("R3 csr", csr_rdata, m_csr);
        chk("R7 fsr", {21'b0, fsr_q}, m_fsr);
        chk("R8 far", far_q, m_far);
        csr_wr_en = 0; dbp_hit = 0; bkpt_insn = 0; pabort = 0; dabort = 0; pc_valid = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        repeat (3) step();
        rst_n = 1;
        // R1 reset state
        chk("R1 trap", {31'b0, trap_req}, 0);
        chk("R1 csr", csr_rdata, 0);
        chk("R1 fsr", {21'b0, fsr_q}, 0);
        chk("R1 far", far_q, 0);

        // R4: disabled, events have no effect
        ibp_regs[0] = 32'h0000_0101; pc = 32'h0000_0102; pc_valid = 1;
        bkpt_insn = 1; dabort = 1; dabort_addr = 32'h55; step();
        step();
        chk("R4 csr disabled", csr_rdata, 0);
        chk("R4 trap disabled", {31'b0, trap_req}, 0);
        chk("R4 fsr disabled", {21'b0, fsr_q}, 0);

        // enable with other bits set
        csr_wr_en = 1; csr_wr_data = 32'h8000_00A1; step();
        // R2 + R3: slot 0 match ignoring pc[1:0]
        pc = 32'h0000_0103; pc_valid = 1; step();
        chk("R2 ibp slot0 trap", {31'b0, trap_req}, 1);
        chk("R3 moe ibp keeps other bits", csr_rdata, 32'h8000_00A5);
        step();
        chk("R6 pulse ends", {31'b0, trap_req}, 0);

        // R11: slot 0 disabled, slot 1 matches; then mismatch
        ibp_regs[0] = 32'h0000_0100; ibp_regs[1] = 32'h0000_2001;
        pc = 32'h0000_0100; pc_valid = 1; step();
        chk("R11 disabled slot no trap", {31'b0, trap_req}, 0);
        pc = 32'h0000_2000; pc_valid = 1; step();
        chk("R2 ibp slot1 trap", {31'b0, trap_req}, 1);
        pc = 32'h0000_2000; pc_valid = 0; step();
        chk("R11 pc_valid low no trap", {31'b0, trap_req}, 0);

        // R3 data breakpoint code, R7 breakpoint instruction capture
        dbp_hit = 1; step();
        chk("R3 moe dbp", {29'b0, csr_rdata[4:2]}, 2);
        pc = 32'h0000_4444; bkpt_insn = 1; step();
        chk("R3 moe bkpt", {29'b0, csr_rdata[4:2]}, 3);
        chk("R7 fsr bkpt", {21'b0, fsr_q}, 32'h400);
        chk("R7 far bkpt", far_q, 32'h0000_4444);

        // R5 priority; R6 back-to-back pulses
        pc = 32'h0000_2000; pc_valid = 1; bkpt_insn = 1; dbp_hit = 1; step();
        chk("R5 ibp wins", {29'b0, csr_rdata[4:2]}, 1);
        bkpt_insn = 1; dbp_hit = 1; pc = 32'h0000_3000; step();
        chk("R5 bkpt over dbp", {29'b0, csr_rdata[4:2]}, 3);
        chk("R6 consecutive pulse", {31'b0, trap_req}, 1);

        // R8 data abort, R7 prefetch abort, R9 collision
        dabort = 1; dabort_addr = 32'hCAFE_0010; step();
        chk("R8 fsr dabort", {21'b0, fsr_q}, 1);
        chk("R8 far dabort", far_q, 32'hCAFE_0010);
        pc = 32'h0000_7770; pabort = 1; step();
        chk("R7 fsr pabort", {21'b0, fsr_q}, 32'h400);
        pc = 32'h0000_8880; pabort = 1; dabort = 1; dabort_addr = 32'h1234; step();
        chk("R9 insn side wins far", far_q, 32'h0000_8880);

        // R10 write collides with event
        csr_wr_en = 1; csr_wr_data = 32'h8000_0F00; dbp_hit = 1; step();
        chk("R10 written value kept", csr_rdata, 32'h8000_0F00);
        chk("R10 trap still raised", {31'b0, trap_req}, 1);

        // R4: disable then events
        csr_wr_en = 1; csr_wr_data = 32'h0000_0010; step();
        bkpt_insn = 1; pabort = 1; dbp_hit = 1; pc = 32'h0000_2000; pc_valid = 1; step();
        chk("R4 csr stays", csr_rdata, 32'h0000_0010);
        chk("R4 far stays", far_q, 32'h0000_8880);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            ibp_regs[0] = {28'h0, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))} | 32'h100;
            ibp_regs[1] = {28'h0, 4'($urandom_range(0, 15))} | 32'h100;
            pc = 32'h100 | 32'($urandom_range(0, 15));
            pc_valid = 1'($urandom_range(0, 1));
            dbp_hit = ($urandom_range(0, 3) == 0);
            bkpt_insn = ($urandom_range(0, 3) == 0);
            pabort = ($urandom_range(0, 5) == 0);
            dabort = ($urandom_range(0, 3) == 0);
            dabort_addr = $urandom;
            csr_wr_en = ($urandom_range(0, 15) == 0);
            csr_wr_data = {($urandom_range(0, 3) != 0), 31'($urandom)};
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule